// File: doc/BRIEF.md
# Reactive Energy Accumulator with Selectable Sign Handling

This block integrates a stream of signed reactive power samples into a 24-bit signed energy register. An upstream datapath supplies one reactive power sample and one active power sample together, with a single valid strobe. At the intended rate of one sample every five master clocks, a 4.096 MHz clock gives one sample about every 1.22 µs. The block adds each accepted sample to the register once, after first shaping it according to a two-bit mode selection.

The mode selection gives three ways to accumulate:

- **Plain signed accumulation.** Negative reactive power lowers the register.
- **Sign-follow accumulation.** This is a tamper-resistant mode. The reactive sample is added or subtracted depending on the sign of the active power sample that arrives with it.
- **Absolute accumulation.** The magnitude of the reactive sample is always added.

The absolute setting takes precedence because it is the most restrictive.

Software reads the energy through a read-with-clear strobe. The value shown in the strobe cycle is the value returned, and the register restarts from zero. A sample accepted in that same cycle is kept. If the signed register runs past either 24-bit limit, it wraps and sets a sticky overflow flag. A one-cycle sign flag marks every point where the sign of the accumulated contribution flips.

Top module: `reactive_energy_acc`

## Requirements
- R1: After a synchronous active-low reset, `energy` is 0, `ovf_flag` is 0 and `sign_flag` is 0.
- R2: With `mode_follow`=0 and `mode_abs`=0, each cycle with `smp_valid`=1 adds the signed `var_smp` to `energy`, visible from the following cycle.
- R3: With `mode_follow`=1 and `mode_abs`=0, an accepted sample adds `var_smp` when `watt_smp` >= 0 and subtracts it when `watt_smp` < 0. A zero active power counts as positive.
- R4: With `mode_abs`=1 and `mode_follow`=0, an accepted sample adds |`var_smp`|, including the most negative input code.
- R5: With both mode bits at 1, the block accumulates exactly as in absolute mode (R4).
- R6: In a cycle with `smp_valid`=0 and `rd_clr`=0, `energy` holds its value. A sample whose strobe is low has no effect.
- R7: While `rd_clr`=1, `energy` shows the value being read. On the next cycle `energy` equals 0 plus the contribution of any sample accepted in the strobe cycle.
- R8: If a sum leaves the range -2^23 to 2^23-1, `energy` wraps modulo 2^24 and `ovf_flag` goes to 1. `ovf_flag` then stays at 1 until reset.
- R9: `sign_flag` is high for exactly the one cycle after an accepted sample whose contribution differs in sign from the contribution of the previous accepted sample. Here "sign" means negative versus non-negative. The first sample after reset never raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Strobe marking a new sample pair |
| var_smp | input | 16 | Signed reactive power sample |
| watt_smp | input | 16 | Signed active power sample sharing the strobe |
| mode_follow | input | 1 | Sign-follow accumulation select |
| mode_abs | input | 1 | Absolute accumulation select, takes precedence |
| rd_clr | input | 1 | Read-with-clear strobe |
| energy | output | 24 | Signed accumulated reactive energy |
| ovf_flag | output | 1 | Sticky wrap indicator |
| sign_flag | output | 1 | One-cycle pulse on contribution sign change |

## Verification
Each of the four mode encodings is driven with reactive samples of both signs, paired with active samples that are positive, negative and exactly zero. This separates a sign-follow mode that inverts on the wrong sign from one that treats zero as negative. It also separates absolute mode from plain signed accumulation. Long runs of full-scale samples in one direction, then in the other, show whether the register wraps and whether the flag stays set. A sample coinciding with the read-with-clear strobe shows whether that sample is lost or double counted. Random mode, strobe and clear patterns mixed with alternating-sign sequences test the sign pulse and the hold behaviour in idle cycles.

// File: rtl/rva_pkg.sv
// Package: shared mode type and decode for the reactive energy accumulator.
// Assumes: the absolute request outranks the sign-follow request.
package rva_pkg;

    typedef enum logic [1:0] {
        ACC_SIGNED = 2'd0,
        ACC_FOLLOW = 2'd1,
        ACC_ABS    = 2'd2
    } acc_mode_e;

    // Map the two request bits onto one mode; absolute wins when both are set.
    function automatic acc_mode_e decode_mode(input logic follow, input logic absval);
        if (absval)      return ACC_ABS;
        else if (follow) return ACC_FOLLOW;
        else             return ACC_SIGNED;
    endfunction

endpackage

// File: rtl/rva_term.sv
// Module: rva_term
// Shapes one reactive sample into the signed contribution to be accumulated,
// according to the decoded mode and the sign of the paired active sample.
// Assumes: PWR_W < ACC_W. The output is ACC_W+1 bits wide so that the
// magnitude of the most negative input code is still representable.
module rva_term
    import rva_pkg::*;
#(
    parameter int PWR_W = 16,
    parameter int ACC_W = 24
) (
    input  logic signed [PWR_W-1:0] var_i,
    input  logic signed [PWR_W-1:0] watt_i,
    input  logic                    follow_i,
    input  logic                    abs_i,
    output logic signed [ACC_W:0]   term_o
);
    localparam int EXT_W = ACC_W + 1;

    logic signed [EXT_W-1:0] var_ext;
    logic signed [EXT_W-1:0] var_neg;
    acc_mode_e               mode;

    // Sign-extend the sample and form its negation.
    always_comb begin
        var_ext = {{(EXT_W-PWR_W){var_i[PWR_W-1]}}, var_i};
        var_neg = -var_ext;
        mode    = decode_mode(follow_i, abs_i);
    end

    // Select the contribution for the current mode.
    always_comb begin
        unique case (mode)
            ACC_ABS:    term_o = var_i[PWR_W-1] ? var_neg : var_ext;
            ACC_FOLLOW: term_o = watt_i[PWR_W-1] ? var_neg : var_ext;
            default:    term_o = var_ext;
        endcase
    end

    // R4 R5: an absolute-mode contribution is never negative.
    always_comb begin
        if (abs_i === 1'b1 && !$isunknown(var_i)) begin
            abs_nonneg_chk: assert (term_o[ACC_W] == 1'b0);
        end
    end

endmodule

// File: rtl/rva_accum.sv
// Module: rva_accum
// Holds the signed energy register. It adds accepted contributions, restarts
// from zero on a read-with-clear and keeps a sticky wrap flag.
// Assumes: |term_i| < 2^(ACC_W-1), so a single add cannot wrap twice.
module rva_accum #(
    parameter int ACC_W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid_i,
    input  logic                   clr_i,
    input  logic signed [ACC_W:0]  term_i,
    output logic signed [ACC_W-1:0] acc_o,
    output logic                   ovf_o
);
    logic signed [ACC_W:0] base;
    logic signed [ACC_W:0] sum;
    logic                  wrap;

    // Choose the starting point (zero on clear) and form the extended sum.
    always_comb begin
        base = clr_i ? '0 : {acc_o[ACC_W-1], acc_o};
        sum  = base + term_i;
        wrap = valid_i && (sum[ACC_W] != sum[ACC_W-1]);
    end

    // Update the energy register.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_o <= '0;
        else if (valid_i) acc_o <= sum[ACC_W-1:0];
        else if (clr_i)   acc_o <= '0;
    end

    // Latch the wrap indication until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    ovf_o <= 1'b0;
        else if (wrap) ovf_o <= 1'b1;
    end

    // R7
    clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !valid_i) |=> (acc_o == '0));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !valid_i) |=> $stable(acc_o));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

endmodule

// File: rtl/rva_sign.sv
// Module: rva_sign
// Emits a one-cycle pulse when an accepted contribution has the opposite
// sign to the previous accepted one (negative versus non-negative).
// Assumes: the first accepted sample after reset only primes the history.
module rva_sign (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic neg_i,
    output logic flag_o
);
    logic last_neg;
    logic primed;

    // Track the sign history and raise the change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_neg <= 1'b0;
            primed   <= 1'b0;
            flag_o   <= 1'b0;
        end else begin
            flag_o <= valid_i && primed && (neg_i != last_neg);
            if (valid_i) begin
                last_neg <= neg_i;
                primed   <= 1'b1;
            end
        end
    end

    // R9
    sign_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o |-> $past(valid_i));

endmodule

// File: rtl/reactive_energy_acc.sv
// Module: reactive_energy_acc (top)
// Integrates reactive power samples into a 24-bit signed energy register in
// signed, sign-follow or absolute mode. It provides read-with-clear, a
// sticky wrap flag and a sign-change pulse.
// Assumes: the sample strobe arrives at most once per cycle (nominally
// every 5 clocks) and the power values are computed upstream.
module reactive_energy_acc #(
    parameter int PWR_W = 16,
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [PWR_W-1:0] var_smp,
    input  logic signed [PWR_W-1:0] watt_smp,
    input  logic                    mode_follow,
    input  logic                    mode_abs,
    input  logic                    rd_clr,
    output logic signed [ACC_W-1:0] energy,
    output logic                    ovf_flag,
    output logic                    sign_flag
);
    logic signed [ACC_W:0] term;

    // R2 R3 R4 R5: contribution shaping.
    rva_term #(.PWR_W(PWR_W), .ACC_W(ACC_W)) term_u (
        .var_i   (var_smp),
        .watt_i  (watt_smp),
        .follow_i(mode_follow),
        .abs_i   (mode_abs),
        .term_o  (term)
    );

    // R6 R7 R8: register, clear and wrap.
    rva_accum #(.ACC_W(ACC_W)) accum_u (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid_i(smp_valid),
        .clr_i  (rd_clr),
        .term_i (term),
        .acc_o  (energy),
        .ovf_o  (ovf_flag)
    );

    // R9: sign-change pulse.
    rva_sign sign_u (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid_i(smp_valid),
        .neg_i  (term[ACC_W]),
        .flag_o (sign_flag)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (energy == '0 && !ovf_flag && !sign_flag));

endmodule

// File: tb/reactive_energy_acc_tb_top.sv
module reactive_energy_acc_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [15:0] var_smp = '0;
    logic signed [15:0] watt_smp = '0;
    logic mode_follow = 1'b0;
    logic mode_abs = 1'b0;
    logic rd_clr = 1'b0;
    logic signed [23:0] energy;
    logic ovf_flag;
    logic sign_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Reference model state.
    logic signed [23:0] m_energy;
    bit m_ovf;
    bit m_sign;
    bit m_last_neg;
    bit m_primed;

    always #4 clk = ~clk;

    reactive_energy_acc dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .var_smp(var_smp),
        .watt_smp(watt_smp), .mode_follow(mode_follow), .mode_abs(mode_abs),
        .rd_clr(rd_clr), .energy(energy), .ovf_flag(ovf_flag), .sign_flag(sign_flag)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected contribution from the requirements.
    function automatic longint contrib(input longint q, input longint p, input bit f, input bit a);
        if (a)      return (q < 0) ? -q : q;
        else if (f) return (p < 0) ? -q : q;
        else        return q;
    endfunction

    function automatic string mode_tag(input bit f, input bit a);
        if (f && a) return "R5";
        if (a)      return "R4";
        if (f)      return "R3";
        return "R2";
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_valid = 1'b0; rd_clr = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_energy = '0; m_ovf = 0; m_sign = 0; m_last_neg = 0; m_primed = 0;
        chk("R1 energy", energy, 0);
        chk("R1 ovf", ovf_flag, 0);
        chk("R1 sign", sign_flag, 0);
    endtask

    task automatic step(input bit v, input logic signed [15:0] q, input logic signed [15:0] p,
                        input bit f, input bit a, input bit c);
        longint t;
        longint s;
        bit neg;
        string tag;
        @(negedge clk);
        smp_valid = v; var_smp = q; watt_smp = p; mode_follow = f; mode_abs = a; rd_clr = c;
        #1;
        if (c) chk("R7 read value", energy, m_energy);
        if (v) begin
            t = contrib(longint'(q), longint'(p), f, a);
            s = (c ? 0 : longint'(m_energy)) + t;
            if (s > 8388607 || s < -8388608) m_ovf = 1;
            m_energy = s[23:0];
            neg = (t < 0);
            m_sign = m_primed && (neg != m_last_neg);
            m_last_neg = neg;
            m_primed = 1;
        end else begin
            if (c) m_energy = '0;
            m_sign = 0;
        end
        tag = c ? "R7" : (v ? mode_tag(f, a) : "R6");
        @(posedge clk); #2;
        chk(tag, energy, m_energy);
        chk("R8", ovf_flag, m_ovf);
        chk("R9", sign_flag, m_sign);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R2 signed mode, negative lowers register
        step(1, 16'sd1000, 16'sd5, 0, 0, 0);
        step(1, -16'sd3000, 16'sd5, 0, 0, 0);
        step(0, 16'sd7777, 16'sd5, 0, 0, 0);           // R6 ignored sample
        // R3 sign-follow with positive, negative and zero active power
        step(1, 16'sd500, -16'sd10, 1, 0, 0);
        step(1, -16'sd200, -16'sd1, 1, 0, 0);
        step(1, -16'sd300, 16'sd0, 1, 0, 0);
        // R4 absolute, including most negative code
        step(1, -16'sd32768, 16'sd3, 0, 1, 0);
        step(1, -16'sd12, -16'sd3, 0, 1, 0);
        // R5 both bits set
        step(1, -16'sd400, -16'sd9, 1, 1, 0);
        // R7 clear alone, then clear with a sample in the same cycle
        step(0, 16'sd0, 16'sd0, 0, 0, 1);
        step(1, 16'sd50, 16'sd0, 0, 0, 0);
        step(1, -16'sd70, 16'sd0, 0, 0, 1);
        // R9 alternating signs
        for (int i = 0; i < 6; i++) step(1, (i % 2) ? -16'sd9 : 16'sd9, 16'sd1, 0, 0, 0);
        // R8 positive wrap and stickiness
        do_reset();
        for (int i = 0; i < 260; i++) step(1, 16'sd32767, 16'sd1, 0, 1, 0);
        step(1, -16'sd5, 16'sd1, 0, 0, 0);
        step(0, 16'sd0, 16'sd0, 0, 0, 1);
        // R8 negative wrap
        do_reset();
        for (int i = 0; i < 260; i++) step(1, 16'sd32767, -16'sd1, 1, 0, 0);
        // Random mix
        do_reset();
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 4) != 0, 16'($urandom), 16'($urandom),
                 1'($urandom), 1'($urandom), ($urandom % 16) == 0);
        end
        step(0, 16'sd0, 16'sd0, 0, 0, 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule